// File: doc/BRIEF.md
# I2C bus start/stop condition qualifier

This block watches the clock and data lines of a multi-master I2C bus, as seen inside a synchronous peripheral, and decides when a genuine START or STOP condition has occurred. A START is a falling data edge while the clock line is high. A STOP is a rising data edge while the clock line is high. Both lines first pass through a two-flop synchronizer. An edge counts as a condition only when three timing windows are all met: the clock has been released long enough, the data line was steady for a setup window before the edge, and both lines keep their levels for a hold window after it. All three windows are whole multiples of a 5-bit detect parameter, counted in peripheral-clock cycles. A fast-mode select halves those multiples. A parameter of zero turns detection off.

On a qualified condition the block raises a one-cycle pulse on the matching output. In the same cycle it updates the controller state that depends on bus conditions: the bus-busy flag, the 3-bit bit counter, the master flag and the transmit-direction flag. The surrounding byte, acknowledge and arbitration logic sets the master and transmit flags and advances the bit counter through single-cycle request inputs. The accept decision is made one cycle after the hold window closes. This is the half-cycle latency rounded up to one full cycle.

Top module: `i2c_cond_detect`

## Requirements
- R1: When `det_param` is 0, no START or STOP pulse is produced and no state changes, whatever the line activity.
- R2: A data edge while the clock line is high is classified by direction: falling (1 to 0) gives a one-cycle `start_o` pulse and rising (0 to 1) gives a one-cycle `stop_o` pulse. The two pulses are never high together.
- R3: An edge is rejected unless the synchronized clock line has been high for at least REL = 2·`det_param` cycles before the edge.
- R4: An edge is rejected unless the synchronized data line held its previous level for at least SU = 4·`det_param` cycles before the edge.
- R5: After the edge, the data line must keep its new level and the clock line must stay high for HD = 2·`det_param` cycles. Otherwise the edge is dropped, and no pulse or state change follows.
- R6: When `fast_mode` is 1, each window becomes its standard value shifted right by one bit, with a floor of 1 cycle.
- R7: `busy_o` becomes 1 in the cycle of a `start_o` pulse and 0 in the cycle of a `stop_o` pulse.
- R8: `bit_cnt_o` becomes 0 on every START or STOP. Otherwise each cycle with `bit_inc` high advances it by one, modulo 8.
- R9: A STOP clears `master_o` and `trx_o`. A START clears `trx_o` only when `master_o` is 0 (slave mode) and leaves `master_o` unchanged.
- R10: `master_set` and `trx_set` each set their flag to 1 one cycle later, unless a STOP is accepted in that same cycle.
- R11: While `rst_n` is low at a clock edge, `busy_o`, `bit_cnt_o`, `master_o`, `trx_o` and both pulses are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Raw bus clock line level |
| sda_i | input | 1 | Raw bus data line level |
| det_param | input | 5 | Detect timing parameter; 0 disables detection |
| fast_mode | input | 1 | 1 halves the timing windows |
| master_set | input | 1 | Request to set the master flag |
| trx_set | input | 1 | Request to set the transmit-direction flag |
| bit_inc | input | 1 | Advance the bit counter by one |
| busy_o | output | 1 | Bus-busy flag |
| start_o | output | 1 | One-cycle pulse on an accepted START |
| stop_o | output | 1 | One-cycle pulse on an accepted STOP |
| bit_cnt_o | output | 3 | Bit counter |
| master_o | output | 1 | Master flag |
| trx_o | output | 1 | Transmit-direction flag |

## Verification
The assertions watch every cycle for the consequences of an accepted condition: the pulses never overlap, and the busy flag, the counter clear and the flag clears agree with each pulse. They also check that a zero parameter suppresses pulses and that the set and increment requests take effect. Whether a given edge should be accepted depends on the release, setup and hold windows and on the fast-mode scaling, and only the bench's scenarios can show that. The bench drives edges that clear or miss each window by a margin and compares the pulses and flags with its own model.

// File: rtl/i2c_cd_pkg.sv
package i2c_cd_pkg;

    typedef enum logic [0:0] {
        QS_IDLE = 1'b0,
        QS_HOLD = 1'b1
    } qstate_e;

    // Scale the detect parameter by a window multiple; fast mode halves it, floor of 1.
    function automatic logic [15:0] win_scale(input logic [7:0] prm, input int unsigned mult,
                                              input logic fast);
        logic [15:0] v;
        v = 16'(prm) * 16'(mult);
        if (fast) v = v >> 1;
        if (v == 16'd0) v = 16'd1;
        return v;
    endfunction

endpackage

// File: rtl/cd_sync.sv
module cd_sync #(
    parameter int N_LINES  = 2,
    parameter int N_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_LINES-1:0] din,
    output logic [N_LINES-1:0] dout
);
    logic [N_LINES-1:0][N_STAGES-1:0] sh_d, sh_q;

    always_comb begin
        for (int i = 0; i < N_LINES; i++) begin
            sh_d[i] = {sh_q[i][N_STAGES-2:0], din[i]};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;   // idle bus reads high
        else        sh_q <= sh_d;
    end

    for (genvar g = 0; g < N_LINES; g++) begin : g_out
        assign dout[g] = sh_q[g][N_STAGES-1];
    end
endmodule

// File: rtl/cd_windows.sv
module cd_windows
    import i2c_cd_pkg::*;
#(
    parameter int P_W      = 5,
    parameter int CNT_W    = 7,
    parameter int REL_MULT = 2,
    parameter int SU_MULT  = 4,
    parameter int HD_MULT  = 2
) (
    input  logic [P_W-1:0]   det_param,
    input  logic             fast_mode,
    output logic             enable,
    output logic [CNT_W-1:0] thr_rel,
    output logic [CNT_W-1:0] thr_su,
    output logic [CNT_W-1:0] thr_hd
);
    localparam int N_WIN = 3;
    localparam int unsigned MULTS [N_WIN] = '{REL_MULT, SU_MULT, HD_MULT};

    logic [N_WIN-1:0][CNT_W-1:0] thr;
    logic [7:0]                  prm8;

    assign prm8   = 8'(det_param);
    assign enable = |det_param;

    for (genvar w = 0; w < N_WIN; w++) begin : g_win
        logic [15:0] full;
        assign full   = win_scale(prm8, MULTS[w], fast_mode);
        assign thr[w] = full[CNT_W-1:0];
    end

    assign thr_rel = thr[0];
    assign thr_su  = thr[1];
    assign thr_hd  = thr[2];
endmodule

// File: rtl/cd_qualify.sv
module cd_qualify
    import i2c_cd_pkg::*;
#(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_s,
    input  logic             sda_s,
    input  logic             enable,
    input  logic [CNT_W-1:0] thr_rel,
    input  logic [CNT_W-1:0] thr_su,
    input  logic [CNT_W-1:0] thr_hd,
    output logic             acc_start,
    output logic             acc_stop
);
    typedef struct packed {
        qstate_e          st;
        logic             sda_prev;
        logic             target;
        logic [CNT_W-1:0] scl_cnt;
        logic [CNT_W-1:0] stab_cnt;
        logic [CNT_W-1:0] hold_cnt;
    } qual_t;

    qual_t q_d, q_q;
    logic  sda_edge;

    always_comb begin
        q_d       = q_q;
        acc_start = 1'b0;
        acc_stop  = 1'b0;
        sda_edge  = (sda_s != q_q.sda_prev);

        q_d.sda_prev = sda_s;
        // Release timer: consecutive cycles with the clock line high (saturating).
        if (!scl_s)                 q_d.scl_cnt = '0;
        else if (q_q.scl_cnt != '1) q_d.scl_cnt = q_q.scl_cnt + 1'b1;
        // Setup timer: consecutive cycles without a data change (saturating).
        if (sda_edge)                q_d.stab_cnt = '0;
        else if (q_q.stab_cnt != '1) q_d.stab_cnt = q_q.stab_cnt + 1'b1;

        unique case (q_q.st)
            QS_IDLE: begin
                if (enable && sda_edge && scl_s &&
                    (q_q.scl_cnt >= thr_rel) && (q_q.stab_cnt >= thr_su)) begin
                    q_d.st       = QS_HOLD;
                    q_d.target   = sda_s;
                    q_d.hold_cnt = '0;
                end
            end
            QS_HOLD: begin
                if (!enable || !scl_s || (sda_s != q_q.target)) begin
                    q_d.st = QS_IDLE;          // qualification lost: drop silently
                end else if ((q_q.hold_cnt + 1'b1) >= thr_hd) begin
                    q_d.st    = QS_IDLE;
                    acc_start = !q_q.target;
                    acc_stop  = q_q.target;
                end else begin
                    q_d.hold_cnt = q_q.hold_cnt + 1'b1;
                end
            end
            default: q_d.st = QS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_q          <= '0;
            q_q.st       <= QS_IDLE;
            q_q.sda_prev <= 1'b1;
        end else begin
            q_q <= q_d;
        end
    end
endmodule

// File: rtl/i2c_cond_detect.sv
module i2c_cond_detect
    import i2c_cd_pkg::*;
#(
    parameter int P_W      = 5,
    parameter int BC_W     = 3,
    parameter int SYNC_STG = 2,
    parameter int REL_MULT = 2,
    parameter int SU_MULT  = 4,
    parameter int HD_MULT  = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scl_i,
    input  logic            sda_i,
    input  logic [P_W-1:0]  det_param,
    input  logic            fast_mode,
    input  logic            master_set,
    input  logic            trx_set,
    input  logic            bit_inc,
    output logic            busy_o,
    output logic            start_o,
    output logic            stop_o,
    output logic [BC_W-1:0] bit_cnt_o,
    output logic            master_o,
    output logic            trx_o
);
    localparam int PMAX  = (1 << P_W) - 1;
    localparam int MMAX0 = (REL_MULT > SU_MULT) ? REL_MULT : SU_MULT;
    localparam int MMAX  = (MMAX0 > HD_MULT) ? MMAX0 : HD_MULT;
    localparam int CNT_W = $clog2(PMAX * MMAX + 2);

    typedef struct packed {
        logic            busy;
        logic            master;
        logic            trx;
        logic [BC_W-1:0] bits;
        logic            start_p;
        logic            stop_p;
    } ctl_t;

    logic [1:0]       raw_lines, sync_lines;
    logic             scl_s, sda_s, enable, acc_start, acc_stop;
    logic [CNT_W-1:0] thr_rel, thr_su, thr_hd;
    ctl_t             c_d, c_q;

    assign raw_lines = {scl_i, sda_i};
    assign scl_s     = sync_lines[1];
    assign sda_s     = sync_lines[0];

    cd_sync #(.N_LINES(2), .N_STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (raw_lines),
        .dout (sync_lines)
    );

    cd_windows #(
        .P_W(P_W), .CNT_W(CNT_W),
        .REL_MULT(REL_MULT), .SU_MULT(SU_MULT), .HD_MULT(HD_MULT)
    ) u_win (
        .det_param(det_param),
        .fast_mode(fast_mode),
        .enable   (enable),
        .thr_rel  (thr_rel),
        .thr_su   (thr_su),
        .thr_hd   (thr_hd)
    );

    cd_qualify #(.CNT_W(CNT_W)) u_qual (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_s    (scl_s),
        .sda_s    (sda_s),
        .enable   (enable),
        .thr_rel  (thr_rel),
        .thr_su   (thr_su),
        .thr_hd   (thr_hd),
        .acc_start(acc_start),
        .acc_stop (acc_stop)
    );

    always_comb begin
        c_d         = c_q;
        c_d.start_p = 1'b0;
        c_d.stop_p  = 1'b0;
        if (master_set) c_d.master = 1'b1;
        if (trx_set)    c_d.trx    = 1'b1;
        if (bit_inc)    c_d.bits   = c_q.bits + 1'b1;
        // Bus conditions take priority over the requests of the same cycle.
        if (acc_start) begin
            c_d.start_p = 1'b1;
            c_d.busy    = 1'b1;
            c_d.bits    = '0;
            if (!c_q.master) c_d.trx = 1'b0;
        end
        if (acc_stop) begin
            c_d.stop_p = 1'b1;
            c_d.busy   = 1'b0;
            c_d.bits   = '0;
            c_d.master = 1'b0;
            c_d.trx    = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) c_q <= '0;
        else        c_q <= c_d;
    end

    assign busy_o    = c_q.busy;
    assign start_o   = c_q.start_p;
    assign stop_o    = c_q.stop_p;
    assign bit_cnt_o = c_q.bits;
    assign master_o  = c_q.master;
    assign trx_o     = c_q.trx;
endmodule

// File: rtl/i2c_cond_detect_chk.sv
module i2c_cond_detect_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       scl_i,
    input logic       sda_i,
    input logic [4:0] det_param,
    input logic       fast_mode,
    input logic       master_set,
    input logic       trx_set,
    input logic       bit_inc,
    input logic       busy_o,
    input logic       start_o,
    input logic       stop_o,
    input logic [2:0] bit_cnt_o,
    input logic       master_o,
    input logic       trx_o
);
    a_r1_off_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(det_param) == 5'd0) |-> (!start_o && !stop_o));

    a_r2_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(start_o && stop_o));

    a_r7_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
        start_o |-> busy_o);

    a_r7_stop_idle: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !busy_o);

    a_r8_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o || stop_o) |-> (bit_cnt_o == 3'd0));

    a_r8_bit_advance: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(bit_inc) && !start_o && !stop_o)
        |-> (bit_cnt_o == 3'($past(bit_cnt_o) + 3'd1)));

    a_r9_stop_flags: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> (!master_o && !trx_o));

    a_r9_slave_start_trx: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && !master_o) |-> !trx_o);

    a_r10_master_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(master_set) && !stop_o) |-> master_o);

    a_r10_trx_set: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(trx_set) && !stop_o && !start_o) |-> trx_o);

    a_r11_reset_clear: assert property (@(posedge clk)
        ($past(rst_n) === 1'b0) |-> (!busy_o && !start_o && !stop_o &&
                                     bit_cnt_o == 3'd0 && !master_o && !trx_o));
endmodule

bind i2c_cond_detect i2c_cond_detect_chk u_chk (.*);

// File: tb/sim_i2c_cond_detect.sv
module sim_i2c_cond_detect;
    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic       rst_n, scl, sda, fast, ms, ts, bi;
    logic [4:0] prm;
    logic       busy, start, stop, master, trx;
    logic [2:0] bits;

    int errors = 0, total = 0, n_st = 0, n_sp = 0;
    bit e_busy = 0, e_master = 0, e_trx = 0;
    int e_bits = 0;

    i2c_cond_detect u0 (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .det_param(prm),
        .fast_mode(fast), .master_set(ms), .trx_set(ts), .bit_inc(bi),
        .busy_o(busy), .start_o(start), .stop_o(stop), .bit_cnt_o(bits),
        .master_o(master), .trx_o(trx)
    );

    always @(negedge clk) if (rst_n === 1'b1) begin
        if (start) n_st++;
        if (stop)  n_sp++;
    end

    task automatic step(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic check_state(input string req);
        @(negedge clk);
        check(req, "busy", int'(busy), int'(e_busy));
        check(req, "bit count", int'(bits), e_bits);
        check(req, "master", int'(master), int'(e_master));
        check(req, "trx", int'(trx), int'(e_trx));
    endtask

    // Window length per the requirements: param*mult, halved in fast mode, floor 1.
    function automatic int thr(input int mult);
        int v;
        v = (int'(prm) * mult) >> fast;
        return (v < 1) ? 1 : v;
    endfunction

    task automatic run_cond(input bit is_stop, input int su, input int rel, input int hd,
                            input bit ok, input string req);
        int s0, t0;
        s0 = n_st; t0 = n_sp;
        scl = 0; sda = is_stop ? 1'b1 : 1'b0; step(3);
        sda = is_stop ? 1'b0 : 1'b1; step(su - rel);
        scl = 1; step(rel);
        sda = is_stop ? 1'b1 : 1'b0; step(hd);
        scl = 0; step(8);
        if (ok) begin
            e_bits = 0;
            if (is_stop) begin e_busy = 0; e_master = 0; e_trx = 0; end
            else begin e_busy = 1; if (!e_master) e_trx = 0; end
        end
        check(req, "start pulses", n_st - s0, int'(ok && !is_stop));
        check(req, "stop pulses", n_sp - t0, int'(ok && is_stop));
        check_state(req);
    endtask

    // mode 0 all windows met, 1 release short, 2 setup short, 3 hold short
    task automatic cond_mode(input bit is_stop, input int mode, input string req);
        int rw, sw, hw, su, rel, hd;
        rw = thr(2); sw = thr(4); hw = thr(2);
        su = sw + 4 + int'($urandom % 6);
        rel = rw + 4 + int'($urandom % 6);
        hd = hw + 4 + int'($urandom % 6);
        case (mode)
            1: rel = rw - 4;
            2: begin su = sw - 4; rel = rw + 4; end
            3: hd = hw - 4;
            default: ;
        endcase
        run_cond(is_stop, su, rel, hd, mode == 0, req);
    endtask

    task automatic pulse_ms(); ms = 1; step(1); ms = 0; e_master = 1; endtask
    task automatic pulse_ts(); ts = 1; step(1); ts = 0; e_trx = 1; endtask
    task automatic pulse_bi(); bi = 1; step(1); bi = 0; e_bits = (e_bits + 1) % 8; endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end

    initial begin
        void'($urandom(32'h1D2C));
        rst_n = 0; scl = 1; sda = 1; prm = 5'd10; fast = 0; ms = 0; ts = 0; bi = 0;
        step(4);
        check_state("R11");
        check("R11", "start pulse in reset", int'(start), 0);
        check("R11", "stop pulse in reset", int'(stop), 0);
        step(1); rst_n = 1; step(2);

        // R1: detection off with a zero parameter
        prm = 5'd0;
        run_cond(0, 60, 30, 30, 0, "R1");
        prm = 5'd10;

        // R2, R7: qualified START then STOP
        cond_mode(0, 0, "R7");
        cond_mode(1, 0, "R2");
        // R3 / R4 / R5: each window missed once
        cond_mode(0, 1, "R3");
        cond_mode(0, 2, "R4");
        cond_mode(0, 3, "R5");
        cond_mode(0, 0, "R7");
        cond_mode(1, 1, "R3");
        cond_mode(1, 2, "R4");
        cond_mode(1, 3, "R5");
        cond_mode(1, 0, "R7");

        // R6: timing that only the halved windows accept
        prm = 5'd12; fast = 1;
        run_cond(0, 40, 16, 16, 1, "R6");
        run_cond(1, 40, 16, 16, 1, "R6");
        fast = 0;
        run_cond(0, 40, 16, 16, 0, "R6");

        // R10: flag requests
        pulse_ts(); pulse_ms();
        check_state("R10");
        // R9: START in master mode keeps trx, STOP clears both
        prm = 5'd10;
        cond_mode(0, 0, "R9");
        cond_mode(1, 0, "R9");
        // R9: START in slave mode clears trx
        pulse_ts();
        check_state("R10");
        cond_mode(0, 0, "R9");

        // R8: counter advances and wraps, then clears on STOP
        for (int i = 0; i < 9; i++) pulse_bi();
        check_state("R8");
        cond_mode(1, 0, "R8");

        // Random mix of conditions, window misses and requests
        for (int it = 0; it < 40; it++) begin
            int mode;
            prm = 5'(10 + ($urandom % 11));
            fast = $urandom % 2;
            if ($urandom % 3 == 0) pulse_ms();
            if ($urandom % 3 == 0) pulse_ts();
            for (int k = 0; k < int'($urandom % 4); k++) pulse_bi();
            check_state("R10");
            mode = int'($urandom % 4);
            case (mode)
                0: cond_mode($urandom % 2, 0, "R2");
                1: cond_mode($urandom % 2, 1, "R3");
                2: cond_mode($urandom % 2, 2, "R4");
                default: cond_mode($urandom % 2, 3, "R5");
            endcase
        end

        // R11: mid-run reset
        pulse_ms(); pulse_ts(); pulse_bi();
        rst_n = 0; step(2);
        e_busy = 0; e_master = 0; e_trx = 0; e_bits = 0;
        check_state("R11");
        rst_n = 1; step(2);

        $display("Result: errors=%0d of %0d checks", errors, total);
        $finish;
    end
endmodule